// File: doc/BRIEF.md
# Queued SPI Master with Per-Frame Attribute Sets

This block is a full-duplex SPI master. Transfers are queued as commands. Each command carries the transmit word, the chip selects to drive, a continuous chip-select flag and an index into a small table of attribute sets. The selected set fixes the frame length, the SCK half period, the lead time from chip select to the first clock edge, and the clock polarity and phase. Consecutive frames can therefore use different timing and different formats.

While a frame runs, the word on `miso` is shifted in at the same time as the transmit word goes out on `mosi`. Each received word is placed in a receive queue. Two level flags, `tx_req` (the command queue has room) and `rx_rdy` (received data is waiting), can drive a DMA engine or an interrupt controller directly. The attribute table is a static input vector held by the surrounding logic. The input reset is asserted asynchronously and released through a synchronizer inside the block.

Top module: `spi_fm_top`

## Requirements
- R1: A command is accepted on a rising clock edge when `cmd_valid` and `tx_req` are both high. `tx_req` is high exactly while the command queue (depth `CMD_DEPTH`) is not full.
- R2: Each frame sends the low N bits of the transmit word on `mosi`, most significant of those bits first. N is the set's size field plus one, clamped to the range 4 to 16, so a field value of 0, 1 or 2 gives 4.
- R3: During the same frame, N bits are received from `miso`. They are delivered right-justified on `rx_data`, with the first received bit as the most significant, and in command order.
- R4: Each frame starts with `sck` at the polarity bit of its attribute set, and `sck` returns to that level after the 2N edges.
- R5: With the phase bit at 0, the first data bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With the phase bit at 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: Consecutive `sck` edges within a frame are exactly H+1 clocks apart, where H is the half-period field. The SCK period is therefore an even count of at least 2 clocks.
- R7: When a frame starts from deasserted chip selects, the first `sck` edge comes D+H+2 clocks after chip select asserts, where D is the lead-delay field.
- R8: During a frame, `cs_n` equals the bitwise inverse of the command's 6-bit mask.
- R9: With the continuous flag clear, all of `cs_n` goes high after the frame for at least one SCK period (2H+2 clocks). With the flag set, chip select stays asserted until the next frame takes over.
- R10: No frame starts while the receive queue is full. Received data is never overwritten or lost, and frames resume once space appears.
- R11: `rx_rdy` is high while the receive queue holds data. A cycle with `rx_pop` high removes the word shown on `rx_data`.
- R12: After reset, `cs_n` is all ones, `sck` is 0, `tx_req` is 1 and `rx_rdy` is 0.

Attribute set k occupies `attr_cfg[22*k +: 22]`, laid out as size field [3:0], half-period H [11:4], lead delay D [19:12], polarity [20] and phase [21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_cfg | input | 88 | Four attribute sets, 22 bits each |
| cmd_valid | input | 1 | Command offered |
| tx_req | output | 1 | Command queue has room |
| cmd_tx | input | 16 | Transmit word |
| cmd_cs | input | 6 | Chip-select mask, bit set = assert |
| cmd_attr | input | 2 | Attribute set index |
| cmd_cont | input | 1 | Keep chip select asserted after this frame |
| rx_data | output | 16 | Oldest received word |
| rx_rdy | output | 1 | Receive queue not empty |
| rx_pop | input | 1 | Remove the oldest received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip selects |

## Verification
The assertions assume that `attr_cfg` does not change while commands that refer to it are queued or in flight. They also assume that `rx_pop` is raised only while `rx_rdy` is high. The bench writes the table once, before the first command, and its drain process pops only after it has seen `rx_rdy` at a falling clock edge. The serial model in the bench changes `miso` only at the falling clock edge after a shift edge, so the value the block samples on a sampling edge has always settled.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  parameter int DATA_W   = 16;
  parameter int CS_W     = 6;
  parameter int AIDX_W   = 2;
  parameter int NUM_ATTR = 1 << AIDX_W;
  parameter int SIZE_W   = 4;
  parameter int HALF_W   = 8;
  parameter int DLY_W    = 8;
  parameter int MIN_BITS = 4;
  parameter int NB_W     = $clog2(DATA_W) + 1;
  parameter int EDGE_W   = $clog2(2 * DATA_W) + 1;
  parameter int CNT_W    = HALF_W + 1;

  typedef struct packed {
    logic              pha;
    logic              pol;
    logic [DLY_W-1:0]  dly;
    logic [HALF_W-1:0] half;
    logic [SIZE_W-1:0] size_m1;
  } attr_t;

  typedef struct packed {
    logic [DATA_W-1:0] tx;
    logic [CS_W-1:0]   cs;
    logic [AIDX_W-1:0] aidx;
    logic              cont;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL, ST_GAP
  } eng_st_t;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (wr_en) wp_d = wp_q + 1'b1;
    if (rd_en) rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rp_q[AW-1:0]];
  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

  // R10: a write never lands on a full queue
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R11: a read never drains an empty queue
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  attr_t             attr_tab [NUM_ATTR],
  input  logic              cmd_avail,
  input  cmd_t              cmd_word,
  output logic              cmd_take,
  input  logic              rx_space,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs_n
);
  eng_st_t           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [NB_W-1:0]   nb_q, nb_d, nb_sel, shamt;
  logic [HALF_W-1:0] half_q, half_d;
  logic              pha_q, pha_d, cont_q, cont_d;
  logic              sck_q, sck_d, mosi_q, mosi_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d, aligned;
  logic [CS_W-1:0]   cs_n_q, cs_n_d;
  logic              lead_edge, last_edge;
  attr_t             sel;

  assign sel       = attr_tab[cmd_word.aidx];
  assign nb_sel    = (sel.size_m1 < SIZE_W'(MIN_BITS - 1)) ? NB_W'(MIN_BITS)
                                                          : NB_W'(sel.size_m1) + 1'b1;
  assign shamt     = NB_W'(DATA_W) - nb_sel;
  assign aligned   = cmd_word.tx << shamt;
  assign lead_edge = ~edge_q[0];
  assign last_edge = (edge_q == ({1'b0, nb_q, 1'b0} - 1'b1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    edge_d   = edge_q;
    nb_d     = nb_q;
    half_d   = half_q;
    pha_d    = pha_q;
    cont_d   = cont_q;
    sck_d    = sck_q;
    mosi_d   = mosi_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    cs_n_d   = cs_n_q;
    cmd_take = 1'b0;
    rx_push  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_avail && rx_space) begin
          cmd_take = 1'b1;
          nb_d     = nb_sel;
          half_d   = sel.half;
          pha_d    = sel.pha;
          cont_d   = cmd_word.cont;
          cs_n_d   = ~cmd_word.cs;
          sck_d    = sel.pol;
          mosi_d   = aligned[DATA_W-1];
          tx_d     = sel.pha ? aligned : (aligned << 1);
          rx_d     = '0;
          edge_d   = '0;
          cnt_d    = CNT_W'(sel.dly);
          state_d  = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          cnt_d   = CNT_W'(half_q);
          state_d = ST_XFER;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_XFER: begin
        if (cnt_q == '0) begin
          sck_d  = ~sck_q;
          edge_d = edge_q + 1'b1;
          cnt_d  = CNT_W'(half_q);
          if (lead_edge ^ pha_q) begin
            rx_d = {rx_q[DATA_W-2:0], miso};
          end else begin
            mosi_d = tx_q[DATA_W-1];
            tx_d   = tx_q << 1;
          end
          if (last_edge) state_d = ST_TAIL;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_TAIL: begin
        if (cnt_q == '0) begin
          rx_push = 1'b1;
          if (cont_q) state_d = ST_IDLE;
          else begin
            cs_n_d  = '1;
            cnt_d   = {half_q, 1'b1};
            state_d = ST_GAP;
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_GAP: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      edge_q  <= '0;
      nb_q    <= NB_W'(MIN_BITS);
      half_q  <= '0;
      pha_q   <= 1'b0;
      cont_q  <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      cs_n_q  <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      edge_q  <= edge_d;
      nb_q    <= nb_d;
      half_q  <= half_d;
      pha_q   <= pha_d;
      cont_q  <= cont_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign cs_n    = cs_n_q;
  assign rx_word = rx_q;

  // R7: no clock edge during the lead delay or the deselect gap
  assert_quiet_sck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD || state_q == ST_GAP) |=> $stable(sck_q));
  // R6: between edge ticks sck and mosi hold
  assert_hold_between_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && cnt_q != '0) |=> ($stable(sck_q) && $stable(mosi_q)));
  // R9: chip selects all released during the gap
  assert_gap_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (&cs_n_q));
  // R2: edge count stays below 2N within a frame
  assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER) |-> (edge_q < {1'b0, nb_q, 1'b0}));
  // R10: a finished word always has room in the receive queue
  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_space);
  // R1: a command is taken only when one is queued
  assert_take_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> cmd_avail);

endmodule

// File: rtl/spi_fm_top.sv
module spi_fm_top
  import spi_fm_pkg::*;
#(
  parameter int CMD_DEPTH   = 4,
  parameter int RX_DEPTH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_ATTR*$bits(attr_t)-1:0]   attr_cfg,
  input  logic                                cmd_valid,
  output logic                                tx_req,
  input  logic [DATA_W-1:0]                   cmd_tx,
  input  logic [CS_W-1:0]                     cmd_cs,
  input  logic [AIDX_W-1:0]                   cmd_attr,
  input  logic                                cmd_cont,
  output logic [DATA_W-1:0]                   rx_data,
  output logic                                rx_rdy,
  input  logic                                rx_pop,
  output logic                                sck,
  output logic                                mosi,
  input  logic                                miso,
  output logic [CS_W-1:0]                     cs_n
);
  localparam int ATTR_W = $bits(attr_t);
  localparam int CMD_W  = $bits(cmd_t);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;
  attr_t                  attr_tab [NUM_ATTR];
  cmd_t                   cmd_in, cmd_out;
  logic                   cmd_full, cmd_empty, cmd_take, cmd_push;
  logic                   rx_full, rx_empty, rx_push, rx_rd;
  logic [DATA_W-1:0]      rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    assign attr_tab[k] = attr_t'(attr_cfg[k*ATTR_W +: ATTR_W]);
  end

  assign cmd_in   = '{tx: cmd_tx, cs: cmd_cs, aidx: cmd_attr, cont: cmd_cont};
  assign cmd_push = cmd_valid & ~cmd_full;
  assign rx_rd    = rx_pop & ~rx_empty;

  spi_fm_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(cmd_push), .wr_data(cmd_in),
    .rd_en(cmd_take), .rd_data(cmd_out),
    .full(cmd_full), .empty(cmd_empty)
  );

  spi_fm_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .attr_tab(attr_tab),
    .cmd_avail(~cmd_empty), .cmd_word(cmd_out), .cmd_take(cmd_take),
    .rx_space(~rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  spi_fm_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(rx_push), .wr_data(rx_word),
    .rd_en(rx_rd), .rd_data(rx_data),
    .full(rx_full), .empty(rx_empty)
  );

  assign tx_req = ~cmd_full;
  assign rx_rdy = ~rx_empty;

endmodule

// File: tb/spi_fm_top_test.sv
module spi_fm_top_test;
  import spi_fm_pkg::*;

  localparam int RXD = 4;

  typedef struct {
    int          nb;
    int          h;
    int          d;
    bit          pol;
    bit          pha;
    bit          cont;
    logic [15:0] tx;
    logic [15:0] rxw;
    logic [5:0]  mask;
  } frame_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [87:0] attr_cfg = '0;
  logic        cmd_valid = 1'b0, cmd_cont = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [15:0] cmd_tx = '0;
  logic [5:0]  cmd_cs = '0;
  logic [1:0]  cmd_attr = '0;
  logic        tx_req, rx_rdy, sck, mosi;
  logic [15:0] rx_data;
  logic [5:0]  cs_n;

  int a_sz[4]  = '{7, 15, 3, 1};
  int a_h[4]   = '{1, 0, 3, 2};
  int a_d[4]   = '{2, 0, 5, 1};
  bit a_pol[4] = '{0, 1, 1, 0};
  bit a_pha[4] = '{0, 1, 0, 1};

  frame_t exp_q[$];
  logic [15:0] rx_exp[$];
  int checks = 0, errors = 0;
  bit done = 0, hold = 0;

  always #2.5 clk = ~clk;

  spi_fm_top uut (
    .clk(clk), .rst_n(rst_n), .attr_cfg(attr_cfg), .cmd_valid(cmd_valid),
    .tx_req(tx_req), .cmd_tx(cmd_tx), .cmd_cs(cmd_cs), .cmd_attr(cmd_attr),
    .cmd_cont(cmd_cont), .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_pop(rx_pop),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send(input int a, input logic [15:0] tx, input logic [5:0] mask, input bit cont);
    frame_t f;
    logic [15:0] m;
    @(negedge clk);
    while (!tx_req) @(negedge clk);
    f.nb   = (a_sz[a] < 3) ? 4 : a_sz[a] + 1;
    m      = 16'((32'h1 << f.nb) - 1);
    f.h    = a_h[a];
    f.d    = a_d[a];
    f.pol  = a_pol[a];
    f.pha  = a_pha[a];
    f.cont = cont;
    f.tx   = tx & m;
    f.rxw  = ((tx * 16'd7) ^ 16'hC3A5) & m;
    f.mask = mask;
    exp_q.push_back(f);
    rx_exp.push_back(f.rxw);
    cmd_valid = 1'b1; cmd_tx = tx; cmd_cs = mask; cmd_attr = 2'(a); cmd_cont = cont;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // serial slave model and timing monitor
  frame_t cur;
  bit active = 0, prev_cont = 0, seen_hi = 0, from_idle = 0, prev_sck = 0;
  int ecnt = 0, bi = 0, cyc = 0, cs_hi_cnt = 0, prev_h = 0, frames_done = 0;
  logic [15:0] mosi_acc;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (&cs_n) begin cs_hi_cnt++; seen_hi = 1; end
      if (!active) begin
        if (exp_q.size() > 0 && !(&cs_n) &&
            (prev_cont ? (sck == exp_q[0].pol) : seen_hi)) begin
          cur = exp_q.pop_front();
          active = 1; ecnt = 0; cyc = 0; prev_sck = sck; mosi_acc = '0;
          from_idle = !prev_cont;
          if (prev_cont) check(cs_hi_cnt == 0, "R9 cont hold", cs_hi_cnt, 0);
          else begin
            check(cs_hi_cnt >= 2 * prev_h + 2, "R9 gap", cs_hi_cnt, 2 * prev_h + 2);
            check(sck == cur.pol, "R4 idle polarity", sck, cur.pol);
          end
          if (!cur.pha) begin miso = cur.rxw[cur.nb-1]; bi = cur.nb - 2; end
          else bi = cur.nb - 1;
        end
      end else if (sck != prev_sck) begin
        bit lead, samp;
        prev_sck = sck;
        lead = (ecnt % 2 == 0);
        samp = cur.pha ? !lead : lead;
        check(cs_n == ~cur.mask, "R8 cs mask", cs_n, ~cur.mask);
        if (ecnt == 0) begin
          if (from_idle) check(cyc == cur.d + cur.h + 2, "R7 lead delay", cyc, cur.d + cur.h + 2);
        end else if (cyc != cur.h + 1) check(0, "R6 half period", cyc, cur.h + 1);
        cyc = 0;
        if (samp) mosi_acc = {mosi_acc[14:0], mosi};
        else if (bi >= 0) begin miso = cur.rxw[bi]; bi--; end
        ecnt++;
        if (ecnt == 2 * cur.nb) begin
          check(mosi_acc == cur.tx, "R2 R5 mosi word", mosi_acc, cur.tx);
          check(sck == cur.pol, "R4 end polarity", sck, cur.pol);
          frames_done++;
          active = 0; prev_cont = cur.cont; prev_h = cur.h;
          cs_hi_cnt = 0; seen_hi = 0;
        end
      end
    end
  end

  // receive scoreboard
  always @(negedge clk) begin
    rx_pop = 1'b0;
    if (rst_n && rx_rdy && !hold) begin
      if (rx_exp.size() == 0) check(0, "R3 unexpected rx", rx_data, 0);
      else begin
        logic [15:0] e;
        e = rx_exp.pop_front();
        check(rx_data == e, "R3 rx word", rx_data, e);
      end
      rx_pop = 1'b1;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    for (int k = 0; k < 4; k++)
      attr_cfg[k*22 +: 22] = {a_pha[k], a_pol[k], 8'(a_d[k]), 8'(a_h[k]), 4'(a_sz[k])};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n == 6'h3F, "R12 cs_n reset", cs_n, 6'h3F);
    check(sck == 1'b0, "R12 sck reset", sck, 0);
    check(tx_req == 1'b1, "R12 tx_req reset", tx_req, 1);
    check(rx_rdy == 1'b0, "R12 rx_rdy reset", rx_rdy, 0);

    send(0, 16'h00A5, 6'b000001, 0);
    send(1, 16'hBEEF, 6'b100000, 1);
    send(1, 16'h1234, 6'b100000, 0);
    send(2, 16'h0009, 6'b000110, 0);
    send(3, 16'hFFF6, 6'b010000, 1);
    send(3, 16'h0003, 6'b010000, 0);
    send(2, 16'hFFFF, 6'b101010, 0);
    send(0, 16'h5A3C, 6'b001000, 0);
    while (exp_q.size() != 0 || rx_exp.size() != 0 || active) @(negedge clk);
    repeat (20) @(negedge clk);

    hold = 1;
    base = frames_done;
    for (int k = 0; k < RXD + 4; k++) send((k % 2 == 0) ? 0 : 3, 16'(16'h1357 * (k + 3)), 6'b000100, 0);
    repeat (400) @(negedge clk);
    check(frames_done - base == RXD, "R10 stall on full rx", frames_done - base, RXD);
    check(&cs_n, "R10 idle while stalled", cs_n, 6'h3F);
    check(tx_req == 1'b0, "R1 queue full", tx_req, 0);
    check(rx_rdy == 1'b1, "R11 rx pending", rx_rdy, 1);
    hold = 0;
    while (exp_q.size() != 0 || rx_exp.size() != 0 || active) @(negedge clk);
    repeat (20) @(negedge clk);
    check(rx_rdy == 1'b0, "R11 drained", rx_rdy, 0);
    check(tx_req == 1'b1, "R1 room again", tx_req, 1);
    finish_run();
  end

endmodule